// File: doc/BRIEF.md
# Multi-channel ADC conversion sequencer

This block is the digital controller for an eight-input successive-approximation converter. Software programs it through a small register bus: a mode word (prescaler, resolution, sleep, start-up time, hardware trigger choice), a channel mask changed through separate set and clear addresses, a status word of per-channel flags, and one result register per channel. One start, either a write to the control address or a rising edge on the chosen trigger input, converts every enabled channel once, lowest index first. After the last channel the block returns to idle and waits for the next start.

Each conversion lasts eleven periods of a conversion clock. That clock is a tick derived from the system clock by the prescaler. The analog cell is reached through a plain handshake. `cell_req` is high for the whole conversion, and `cell_chan` names the input. The cell's 10-bit `cell_code` is sampled on the final tick. A completed result sets that channel's end-of-conversion flag, which drives `irq`. It sets the overrun flag instead when the previous result was never read. In sleep mode the cell is powered only while a sequence runs, and a start-up wait comes before the first conversion.

The controller has three states. `ST_IDLE` goes to `ST_WAKE` (sleep on) or to `ST_CONV` (sleep off) on an accepted start. `ST_WAKE` goes to `ST_CONV` when the start-up time expires. `ST_CONV` stays in `ST_CONV` when a channel finishes and others remain, and goes back to `ST_IDLE` after the last one.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A conversion keeps `cell_req` high with `cell_chan` steady for exactly 11 conversion-clock periods, then stores `cell_code` as sampled on the last system cycle of that window.
- R2: The conversion-clock period is 2×(P+1) system clocks, where P is MODE[13:8]. A sequence of N channels therefore holds `cell_req` high for 22×(P+1)×N cycles.
- R3: A finished channel c writes its result to DATA register 0x8+c and sets STATUS bit c. `irq` is high while any such bit is set. A read of DATA c clears STATUS bit c.
- R4: When a result arrives on channel c while STATUS bit c is still set, STATUS bit 8+c is set. Any read of STATUS (0x5) clears all bits 15:8 and leaves bits 7:0 alone.
- R5: After reset the resolution is 10 bits. With MODE[4]=1 the stored value is `cell_code` shifted right by 2, and DATA bits 9:8 read 0.
- R6: A write to CTRL (0x0) with bit 0 set starts a sequence.
- R7: With MODE[0]=1, a rising edge on `trig_in[MODE[2:1]]` starts a sequence. Edges on other inputs, and any edge while MODE[0]=0, start nothing.
- R8: A sequence converts every channel enabled at the start, once each, in ascending index order, and then returns to idle with `cell_req` low.
- R9: Writing CHEN (0x2) sets the mask bits given by ones in the data. Writing CHDIS (0x3) clears them. CHSTAT (0x4) reads the mask.
- R10: With MODE[5]=1, `cell_pwr` is low in idle. After a start it rises at once, and `cell_req` follows after (S+1)×2×(P+1) cycles, where S is MODE[23:16]. With MODE[5]=0, `cell_pwr` stays high.
- R11: A start that arrives during a sequence is ignored. A start with no channel enabled does nothing.
- R12: After reset, MODE, CHSTAT and STATUS read 0, `cell_req` and `irq` are low, and `cell_pwr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives read side effects) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| trig_in | input | 4 | Hardware trigger candidates |
| cell_code | input | 10 | Code returned by the analog cell |
| cell_pwr | output | 1 | Analog cell power enable |
| cell_req | output | 1 | Conversion in progress |
| cell_chan | output | 3 | Channel being converted |
| irq | output | 1 | Any end-of-conversion flag set |

## Verification
Sequences are swept over three prescaler settings and five channel masks: one low channel, one high channel, a sparse pattern, a contiguous run and all eight. The measured `cell_req` length separates errors in the tick period from errors in the tick count. The recorded channel order exposes skipped, repeated or misordered channels. A bench model whose code depends on channel and run makes each stored result traceable, so a crossed register or a stale value shows up. Separate runs cover back-to-back sequences without reads (overrun against plain completion), 8-bit against 10-bit storage, the selected trigger against an unselected or disabled one, starts during a sequence or with an empty mask, and the sleep start-up delay.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_WAKE, ST_CONV} seq_state_t;

    localparam int A_CTRL   = 0;
    localparam int A_MODE   = 1;
    localparam int A_CHEN   = 2;
    localparam int A_CHDIS  = 3;
    localparam int A_CHSTAT = 4;
    localparam int A_STATUS = 5;
    localparam int A_DATA0  = 8;

    localparam int M_TRGEN     = 0;
    localparam int M_TSEL_LSB  = 1;
    localparam int M_RES8      = 4;
    localparam int M_SLEEP     = 5;
    localparam int M_PRESC_LSB = 8;
    localparam int M_SU_LSB    = 16;
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
    parameter int PRESC_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick
);
    localparam int CW = PRESC_W + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    assign limit = {presc, 1'b1};
    assign tick  = run && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt <= '0;
        else if (!run || cnt == limit) cnt <= '0;
        else                          cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
    parameter int N_CH = 8,
    parameter int CH_W = 3
) (
    input  logic [N_CH-1:0] mask,
    output logic            any,
    output logic [CH_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (mask[i]) idx = CH_W'(i);
        end
    end
    assign any = |mask;
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int N_CH   = 8,
    parameter int CH_W   = 3,
    parameter int CODE_W = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [CH_W-1:0]        wr_ch,
    input  logic [CODE_W-1:0]      wr_val,
    input  logic                   rd_data,
    input  logic [CH_W-1:0]        rd_ch,
    input  logic                   rd_status,
    output logic [N_CH*CODE_W-1:0] data_flat,
    output logic [N_CH-1:0]        eoc,
    output logic [N_CH-1:0]        ovr
);
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic hit_wr, hit_rd;
        assign hit_wr = wr_en && (wr_ch == CH_W'(g));
        assign hit_rd = rd_data && (rd_ch == CH_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_flat[g*CODE_W +: CODE_W] <= '0;
                eoc[g] <= 1'b0;
                ovr[g] <= 1'b0;
            end else if (hit_wr) begin
                data_flat[g*CODE_W +: CODE_W] <= wr_val;
                eoc[g] <= 1'b1;
                if (eoc[g] && !hit_rd) ovr[g] <= 1'b1;
                else if (rd_status)    ovr[g] <= 1'b0;
            end else begin
                if (hit_rd)    eoc[g] <= 1'b0;
                if (rd_status) ovr[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int N_CH       = 8,
    parameter int CODE_W     = 10,
    parameter int CONV_TICKS = 11,
    parameter int PRESC_W    = 6,
    parameter int SU_W       = 8,
    parameter int TRIG_N     = 4,
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [TRIG_N-1:0]           trig_in,
    input  logic [CODE_W-1:0]           cell_code,
    output logic                        cell_pwr,
    output logic                        cell_req,
    output logic [$clog2(N_CH)-1:0]     cell_chan,
    output logic                        irq
);
    localparam int CH_W   = $clog2(N_CH);
    localparam int CNT_W  = $clog2(CONV_TICKS);
    localparam int TSEL_W = (TRIG_N > 1) ? $clog2(TRIG_N) : 1;
    localparam int SHIFT8 = CODE_W - 8;

    seq_state_t state, state_nx;

    logic                    trg_en, res8, sleep;
    logic [TSEL_W-1:0]       tsel;
    logic [PRESC_W-1:0]      presc;
    logic [SU_W-1:0]         su, su_cnt;
    logic [N_CH-1:0]         chen, seq_mask, rem_mask, eoc, ovr;
    logic [CH_W-1:0]         cur_ch, first_ch, rem_ch, rd_ch;
    logic                    first_any, rem_any;
    logic [CNT_W-1:0]        bit_cnt;
    logic                    trig_q, tick, last_tick, store, accept;
    logic                    sw_start, hw_start, data_hit;
    logic [CODE_W-1:0]       conv_val;
    logic [N_CH*CODE_W-1:0]  data_flat;
    logic                    unused_wdata;
    int                      addr_i;

    assign unused_wdata = ^bus_wdata;
    assign addr_i    = int'(bus_addr);
    assign data_hit  = (addr_i >= A_DATA0) && (addr_i < A_DATA0 + N_CH);
    assign rd_ch     = CH_W'(addr_i - A_DATA0);
    assign sw_start  = bus_wr && (addr_i == A_CTRL) && bus_wdata[0];
    assign hw_start  = trg_en && trig_in[tsel] && !trig_q;
    assign accept    = (state == ST_IDLE) && (sw_start || hw_start) && first_any;
    assign last_tick = tick && (bit_cnt == CNT_W'(CONV_TICKS - 1));
    assign store     = (state == ST_CONV) && last_tick;
    assign rem_mask  = seq_mask & ~(N_CH'(1) << cur_ch);
    assign conv_val  = res8 ? (cell_code >> SHIFT8) : cell_code;

    adc_tick_gen #(.PRESC_W(PRESC_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(state != ST_IDLE), .presc(presc), .tick(tick)
    );

    adc_chan_pick #(.N_CH(N_CH), .CH_W(CH_W)) u_pick_first (
        .mask(chen), .any(first_any), .idx(first_ch)
    );

    adc_chan_pick #(.N_CH(N_CH), .CH_W(CH_W)) u_pick_rem (
        .mask(rem_mask), .any(rem_any), .idx(rem_ch)
    );

    adc_result_bank #(.N_CH(N_CH), .CH_W(CH_W), .CODE_W(CODE_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(store), .wr_ch(cur_ch), .wr_val(conv_val),
        .rd_data(bus_rd && data_hit), .rd_ch(rd_ch),
        .rd_status(bus_rd && (addr_i == A_STATUS)),
        .data_flat(data_flat), .eoc(eoc), .ovr(ovr)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = sleep ? ST_WAKE : ST_CONV;
            ST_WAKE: if (tick && su_cnt == su) state_nx = ST_CONV;
            ST_CONV: if (store && !rem_any) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // sequencing counters, channel tracking and configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0; su_cnt <= '0; seq_mask <= '0; cur_ch <= '0; trig_q <= 1'b0;
            trg_en <= 1'b0; tsel <= '0; res8 <= 1'b0; sleep <= 1'b0;
            presc <= '0; su <= '0; chen <= '0;
        end else begin
            trig_q <= trig_in[tsel];
            if (accept) begin
                seq_mask <= chen;
                cur_ch   <= first_ch;
            end else if (store) begin
                seq_mask <= rem_mask;
                cur_ch   <= rem_ch;
            end
            if (state != ST_CONV)   bit_cnt <= '0;
            else if (last_tick)     bit_cnt <= '0;
            else if (tick)          bit_cnt <= bit_cnt + 1'b1;
            if (state != ST_WAKE)   su_cnt <= '0;
            else if (tick)          su_cnt <= su_cnt + 1'b1;
            if (bus_wr) begin
                if (addr_i == A_MODE) begin
                    trg_en <= bus_wdata[M_TRGEN];
                    tsel   <= bus_wdata[M_TSEL_LSB +: TSEL_W];
                    res8   <= bus_wdata[M_RES8];
                    sleep  <= bus_wdata[M_SLEEP];
                    presc  <= bus_wdata[M_PRESC_LSB +: PRESC_W];
                    su     <= bus_wdata[M_SU_LSB +: SU_W];
                end
                if (addr_i == A_CHEN)  chen <= chen | bus_wdata[N_CH-1:0];
                if (addr_i == A_CHDIS) chen <= chen & ~bus_wdata[N_CH-1:0];
            end
        end
    end

    // outputs
    always_comb begin
        cell_pwr  = !sleep || (state != ST_IDLE);
        cell_req  = (state == ST_CONV);
        cell_chan = cur_ch;
        irq       = |eoc;
        bus_rdata = '0;
        if (data_hit) begin
            bus_rdata[CODE_W-1:0] = data_flat[rd_ch*CODE_W +: CODE_W];
        end else if (addr_i == A_MODE) begin
            bus_rdata[M_TRGEN]                  = trg_en;
            bus_rdata[M_TSEL_LSB +: TSEL_W]     = tsel;
            bus_rdata[M_RES8]                   = res8;
            bus_rdata[M_SLEEP]                  = sleep;
            bus_rdata[M_PRESC_LSB +: PRESC_W]   = presc;
            bus_rdata[M_SU_LSB +: SU_W]         = su;
        end else if (addr_i == A_CHSTAT) begin
            bus_rdata[N_CH-1:0] = chen;
        end else if (addr_i == A_STATUS) begin
            bus_rdata[N_CH-1:0]    = eoc;
            bus_rdata[N_CH +: N_CH] = ovr;
        end
    end
endmodule

// File: rtl/adc_seq_checks.sv
module adc_seq_checks
    import adc_seq_pkg::*;
#(
    parameter int N_CH = 8,
    parameter int CH_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cell_req,
    input logic            cell_pwr,
    input logic [CH_W-1:0] cell_chan,
    input logic            irq,
    input logic            store,
    input seq_state_t      state,
    input logic [N_CH-1:0] seq_mask
);
    // R8: within one sequence the channel index only moves upward
    a_r8_chan_ascends: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_req && $past(cell_req) && (cell_chan != $past(cell_chan)))
            |-> (cell_chan > $past(cell_chan)));

    // R10: the cell is powered whenever a conversion runs
    a_r10_pwr_during_conv: assert property (@(posedge clk) disable iff (!rst_n)
        cell_req |-> cell_pwr);

    // R10: no conversion during the start-up wait
    a_r10_wake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE) |-> !cell_req);

    // R3: a stored result raises the interrupt on the next cycle
    a_r3_store_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> irq);

    // R11: a running sequence never gains channels (later starts are ignored)
    a_r11_mask_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && $past(state != ST_IDLE))
            |-> ((seq_mask & ~$past(seq_mask)) == '0));
endmodule

bind adc_seq_ctrl adc_seq_checks #(.N_CH(N_CH), .CH_W(CH_W)) u_checks (
    .clk(clk), .rst_n(rst_n), .cell_req(cell_req), .cell_pwr(cell_pwr),
    .cell_chan(cell_chan), .irq(irq), .store(store), .state(state),
    .seq_mask(seq_mask)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  trig_in = '0;
    logic [9:0]  cell_code;
    logic        cell_pwr, cell_req, irq;
    logic [2:0]  cell_chan;

    int checks = 0, fails = 0, salt = 0;
    int req_cycles = 0, wake_cycles = 0, ocnt = 0;
    int order [0:15];
    logic req_q = 1'b0;
    logic [2:0] chan_q = '0;

    always #4 clk = ~clk;

    adc_seq_ctrl i_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trig_in(trig_in), .cell_code(cell_code), .cell_pwr(cell_pwr),
        .cell_req(cell_req), .cell_chan(cell_chan), .irq(irq)
    );

    function automatic logic [9:0] code_of(input int ch, input int s);
        return 10'((s * 37 + ch * 91 + 5) & 1023);
    endfunction

    assign cell_code = code_of(int'(cell_chan), salt);

    function automatic logic [31:0] mode_val(input int trgen, input int tsel, input int r8,
                                             input int slp, input int p, input int s);
        return 32'(trgen | (tsel << 1) | (r8 << 4) | (slp << 5) | (p << 8) | (s << 16));
    endfunction

    // monitor samples 2 ns after each rising edge
    always begin
        @(posedge clk); #2;
        if (cell_req) req_cycles++;
        if (cell_pwr && !cell_req) wake_cycles++;
        if (cell_req && (!req_q || cell_chan != chan_q)) begin
            if (ocnt < 16) order[ocnt] = int'(cell_chan);
            ocnt++;
        end
        req_q = cell_req;
        chan_q = cell_chan;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = 4'(a); #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic mon_clear();
        @(negedge clk); req_cycles = 0; wake_cycles = 0; ocnt = 0;
    endtask

    task automatic wait_seq();
        do @(negedge clk); while (!cell_req);
        do @(negedge clk); while (cell_req);
        @(negedge clk);
    endtask

    task automatic set_mask(input logic [7:0] m);
        wr(3, 32'hFF); wr(2, {24'b0, m});
    endtask

    task automatic check_order(input logic [7:0] m, input string tag);
        int k = 0;
        for (int i = 0; i < 8; i++) begin
            if (m[i]) begin
                chk(tag, (k < ocnt) ? 32'(order[k]) : 32'hDEAD, 32'(i));
                k++;
            end
        end
        chk(tag, 32'(ocnt), 32'($countones(m)));
    endtask

    task automatic read_results(input logic [7:0] m, input int s, input string tag);
        logic [31:0] d;
        for (int i = 0; i < 8; i++) begin
            if (m[i]) begin
                rd(8 + i, d);
                chk(tag, d, {22'b0, code_of(i, s)});
            end
        end
    endtask

    initial begin
        #(8 * 150000);
        checks++; fails++;
        $display("FAIL R12 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [7:0] masks [0:4];
        int ps [0:2];
        masks[0] = 8'h01; masks[1] = 8'hA5; masks[2] = 8'h80; masks[3] = 8'hFF; masks[4] = 8'h3C;
        ps[0] = 0; ps[1] = 1; ps[2] = 3;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        rd(1, d); chk("R12 mode", d, 0);
        rd(4, d); chk("R12 chstat", d, 0);
        rd(5, d); chk("R12 status", d, 0);
        chk("R12 req", 32'(cell_req), 0);
        chk("R12 irq", 32'(irq), 0);
        chk("R12 pwr", 32'(cell_pwr), 1);

        // R9 mask set / clear
        wr(2, 32'hA5); rd(4, d); chk("R9 set", d, 32'hA5);
        wr(3, 32'h21); rd(4, d); chk("R9 clear", d, 32'h84);
        wr(2, 32'h01); rd(4, d); chk("R9 set again", d, 32'h85);

        // R1 R2 R3 R6 R8 sweep
        for (int pi = 0; pi < 3; pi++) begin
            for (int mi = 0; mi < 5; mi++) begin
                wr(1, mode_val(0, 0, 0, 0, ps[pi], 0));
                set_mask(masks[mi]);
                salt++;
                mon_clear();
                wr(0, 32'h1);
                wait_seq();
                chk("R1 R2 length", 32'(req_cycles),
                    32'(22 * (ps[pi] + 1) * $countones(masks[mi])));
                check_order(masks[mi], "R8 order");
                chk("R3 irq set", 32'(irq), 1);
                rd(5, d); chk("R3 eoc flags", d, {24'b0, masks[mi]});
                read_results(masks[mi], salt, "R3 data");
                rd(5, d); chk("R3 eoc cleared", d, 0);
                chk("R3 irq clear", 32'(irq), 0);
            end
        end

        // R4 overrun
        wr(1, mode_val(0, 0, 0, 0, 0, 0));
        set_mask(8'h06);
        salt++; wr(0, 1); wait_seq();
        salt++; wr(0, 1); wait_seq();
        rd(5, d); chk("R4 ovr set", d, 32'h0606);
        rd(5, d); chk("R4 ovr cleared by status", d, 32'h0006);
        read_results(8'h06, salt, "R4 newest data");

        // R5 8-bit mode
        wr(1, mode_val(0, 0, 1, 0, 0, 0));
        set_mask(8'h10);
        salt++; wr(0, 1); wait_seq();
        rd(12, d); chk("R5 8-bit value", d, 32'(code_of(4, salt) >> 2));
        wr(1, mode_val(0, 0, 0, 0, 0, 0));
        salt++; wr(0, 1); wait_seq();
        rd(12, d); chk("R5 10-bit value", d, 32'(code_of(4, salt)));

        // R7 hardware trigger
        wr(1, mode_val(1, 2, 0, 0, 0, 0));
        set_mask(8'h09);
        mon_clear();
        @(negedge clk); trig_in[1] = 1'b1; @(negedge clk); trig_in[1] = 1'b0;
        repeat (40) @(negedge clk);
        chk("R7 unselected input", 32'(req_cycles), 0);
        salt++;
        @(negedge clk); trig_in[2] = 1'b1;
        wait_seq();
        trig_in[2] = 1'b0;
        chk("R7 selected edge", 32'(req_cycles), 44);
        check_order(8'h09, "R7 order");
        read_results(8'h09, salt, "R7 data");
        wr(1, mode_val(0, 2, 0, 0, 0, 0));
        mon_clear();
        @(negedge clk); trig_in[2] = 1'b1; @(negedge clk); trig_in[2] = 1'b0;
        repeat (40) @(negedge clk);
        chk("R7 disabled", 32'(req_cycles), 0);

        // R11 start during sequence, start with empty mask
        wr(1, mode_val(0, 0, 0, 0, 0, 0));
        set_mask(8'h03);
        salt++; mon_clear();
        wr(0, 1);
        repeat (5) @(negedge clk);
        wr(0, 1);
        wait_seq();
        repeat (30) @(negedge clk);
        chk("R11 restart ignored", 32'(req_cycles), 44);
        read_results(8'h03, salt, "R11 data");
        set_mask(8'h00);
        mon_clear();
        wr(0, 1);
        repeat (30) @(negedge clk);
        chk("R11 empty mask", 32'(req_cycles), 0);
        rd(5, d); chk("R11 no flags", d, 0);

        // R10 sleep with start-up wait
        wr(1, mode_val(0, 0, 0, 1, 1, 3));
        set_mask(8'h01);
        @(negedge clk);
        chk("R10 pwr off idle", 32'(cell_pwr), 0);
        salt++; mon_clear();
        wr(0, 1);
        wait_seq();
        chk("R10 wake length", 32'(wake_cycles), 16);
        chk("R10 conv length", 32'(req_cycles), 44);
        chk("R10 pwr off after", 32'(cell_pwr), 0);
        read_results(8'h01, salt, "R10 data");
        wr(1, mode_val(0, 0, 0, 0, 1, 3));
        @(negedge clk);
        chk("R10 pwr on no sleep", 32'(cell_pwr), 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule